// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block turns selected general-purpose pin inputs into four independent interrupt requests, one per channel (A, B, C, D). Each channel watches one pin. Channels A and B are tied to fixed pin numbers chosen by parameter. Channels C and D each pick any pin through their own select input. The value seen on a pin is taken from the ordinary digital input path, so a pin that a peripheral uses, or that is driven as an output, can still raise an interrupt. A pin marked as analog reads as a constant high.

Every channel brings its pin into the clock domain through a two-flop synchroniser. An optional glitch filter can then require a run of equal samples before it accepts a new level. A trigger detector follows, set by a 3-bit mode code for edges or levels. The result sets a pending flag, which drives that channel's interrupt output. Software clears a flag by pulsing a write strobe with a mask, where a 1 clears the flag and a 0 leaves it alone. An edge that arrives in the same cycle as the clear wins over the clear. In a level mode the clear does take effect, and the flag returns on the next cycle if the input is still active.

Top module: `xirq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all four flags are cleared, and `irq_o` reads 4'b0000 after that edge.
- R2: With the filter off, a pin change made before clock edge k is first reflected in the flag after edge k+2 (two synchroniser flops, then the flag register).
- R3: Mode code 1 sets the flag on a rising input, code 2 on a falling input, and code 3 on either change. A change in the opposite direction has no effect.
- R4: Mode code 4 sets the flag in every cycle in which the input is high, and code 5 in every cycle in which it is low. Once the input is inactive, a cleared flag stays cleared.
- R5: Mode codes 0, 6 and 7 never set the flag. A flag that is already set keeps its value until it is cleared.
- R6: When `clr_we_i` is high at a clock edge, each flag whose bit in `clr_mask_i` is 1 is cleared. Flags whose mask bit is 0 are unchanged.
- R7: If an edge event and a clear of the same channel happen at the same edge, the flag is 1 after that edge.
- R8: In a level mode, a clear while the input is active gives a flag of 0 for exactly one cycle, after which it is set again.
- R9: With the channel's filter bit set, a new level is accepted only after FILT_LEN consecutive equal synchronised samples. A pulse of FILT_LEN-1 cycles is ignored and a pulse of FILT_LEN cycles is taken. With the filter off, a one-cycle pulse sets an edge-mode flag.
- R10: Channel A reads pin PIN_A (default 0) and channel B reads pin PIN_B (default 1). Channel C reads the pin numbered by `sel_c_i`, channel D the pin numbered by `sel_d_i`. Other pins have no effect on a channel.
- R11: A pin whose `pin_analog_i` bit is 1 is seen by every channel as constant high, whatever `pin_i` carries.
- R12: `irq_o` bit 0 is the flag of channel A, bit 1 of B, bit 2 of C and bit 3 of D. `mode_i` holds channel i's code in bits [3i+2:3i], and `filt_en_i` bit i is channel i's filter enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Pin digital input values |
| pin_analog_i | input | NUM_PINS | 1 = pin in analog mode (reads high) |
| mode_i | input | 12 | Trigger mode code, 3 bits per channel |
| filt_en_i | input | 4 | Filter enable per channel |
| sel_c_i | input | SELW | Pin number for channel C |
| sel_d_i | input | SELW | Pin number for channel D |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 4 | 1 = clear that channel's flag |
| irq_o | output | 4 | Pending flags / interrupt lines |

## Verification
The directed tests drive single rising and falling transitions in every edge mode, so a wrong polarity or a missing direction shows up as a wrong flag. Held levels, with clears given while the input is active and again once it is inactive, separate the level re-arm from edge behaviour. Pulses of FILT_LEN-1 and FILT_LEN cycles, with the filter on and with it off, locate the filter's acceptance threshold exactly. Activity on unselected pins, on analog pins, and clears that coincide with edges checks pin routing and the set-over-clear rule. A long random phase with changing modes, selects and clears is then compared every cycle against a behavioural model.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int NCH = 4;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        TM_OFF  = 3'd0,
        TM_RISE = 3'd1,
        TM_FALL = 3'd2,
        TM_BOTH = 3'd3,
        TM_HIGH = 3'd4,
        TM_LOW  = 3'd5,
        TM_RSV6 = 3'd6,
        TM_RSV7 = 3'd7
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       filt;
    } chan_cfg_t;

    typedef struct packed {
        logic edge_hit;
        logic lvl_hit;
    } trig_hit_t;

    function automatic logic is_level_mode(trig_mode_e m);
        return (m == TM_HIGH) || (m == TM_LOW);
    endfunction

    function automatic trig_hit_t classify(trig_mode_e m, logic cur, logic prev);
        trig_hit_t h;
        h = '0;
        unique case (m)
            TM_RISE: h.edge_hit = cur & ~prev;
            TM_FALL: h.edge_hit = ~cur & prev;
            TM_BOTH: h.edge_hit = cur ^ prev;
            TM_HIGH: h.lvl_hit  = cur;
            TM_LOW:  h.lvl_hit  = ~cur;
            default: h = '0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/xirq_pin_sel.sv
module xirq_pin_sel #(
    parameter int NUM_PINS = 16,
    parameter int SELW     = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] analog_i,
    input  logic [SELW-1:0]     idx_i,
    output logic                bit_o
);
    logic [NUM_PINS-1:0] eff;

    // analog pins present a constant high to the digital path
    assign eff = pin_i | analog_i;

    always_comb begin
        bit_o = 1'b0;
        if ({1'b0, idx_i} < (SELW+1)'(NUM_PINS))
            bit_o = eff[idx_i];
    end
endmodule

// File: rtl/xirq_sync.sv
module xirq_sync (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

    p_sync_two_stage_r2: assert property (@(posedge clk) disable iff (rst)
        $past(meta_q) == q_o);
endmodule

// File: rtl/xirq_filter.sv
module xirq_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_i,
    output logic lvl_o
);
    localparam int CNTW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNTW-1:0] CNT_MAX = CNTW'(FILT_LEN - 1);

    logic            cand_q;
    logic [CNTW-1:0] cnt_q;
    logic            lvl_q;
    logic            same;
    logic            run_ok;

    assign same   = (smp_i == cand_q);
    assign run_ok = same && (int'(cnt_q) >= FILT_LEN - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= 1'b0;
            cnt_q  <= CNT_MAX;
            lvl_q  <= 1'b0;
        end else begin
            cand_q <= smp_i;
            if (!same)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            if (run_ok)
                lvl_q <= smp_i;
        end
    end

    assign lvl_o = lvl_q;

    // the filtered level only ever moves to the value just sampled
    p_filter_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(smp_i)));
    // a sample that differs from the previous one can never be accepted at once
    p_filter_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (smp_i != cand_q) |=> $stable(lvl_q));
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
    import xirq_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg_i,
    input  logic      raw_i,
    input  logic      clr_i,
    output logic      flag_o
);
    logic      sync_lvl;
    logic      filt_lvl;
    logic      cur_lvl;
    logic      prev_q;
    logic      flag_q;
    trig_hit_t hit;
    logic      set_ev;

    xirq_sync u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_i),
        .q_o (sync_lvl)
    );

    xirq_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .smp_i (sync_lvl),
        .lvl_o (filt_lvl)
    );

    assign cur_lvl = cfg_i.filt ? filt_lvl : sync_lvl;
    assign hit     = classify(cfg_i.mode, cur_lvl, prev_q);
    // edge events beat a clear; level requests yield to it for one cycle
    assign set_ev  = hit.edge_hit | (hit.lvl_hit & ~clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= cur_lvl;
            flag_q <= set_ev | (flag_q & ~clr_i);
        end
    end

    assign flag_o = flag_q;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (hit.edge_hit && clr_i) |=> flag_q);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit.edge_hit) |=> !flag_q);
    p_level_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (is_level_mode(cfg_i.mode) && hit.lvl_hit && !clr_i) |=> flag_q);
    p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_i.mode == TM_OFF || cfg_i.mode == TM_RSV6 || cfg_i.mode == TM_RSV7)
         && !flag_q) |=> !flag_q);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int FILT_LEN = 4,
    parameter int PIN_A    = 0,
    parameter int PIN_B    = 1,
    parameter int SELW     = $clog2(NUM_PINS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PINS-1:0]     pin_i,
    input  logic [NUM_PINS-1:0]     pin_analog_i,
    input  logic [NCH*MODE_W-1:0]   mode_i,
    input  logic [NCH-1:0]          filt_en_i,
    input  logic [SELW-1:0]         sel_c_i,
    input  logic [SELW-1:0]         sel_d_i,
    input  logic                    clr_we_i,
    input  logic [NCH-1:0]          clr_mask_i,
    output logic [NCH-1:0]          irq_o
);
    logic [SELW-1:0] ch_idx [NCH];
    logic [NCH-1:0]  ch_raw;
    logic [NCH-1:0]  ch_clr;
    chan_cfg_t       ch_cfg [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == 0) begin : g_fix_a
            assign ch_idx[i] = SELW'(PIN_A);
        end else if (i == 1) begin : g_fix_b
            assign ch_idx[i] = SELW'(PIN_B);
        end else if (i == 2) begin : g_sel_c
            assign ch_idx[i] = sel_c_i;
        end else begin : g_sel_d
            assign ch_idx[i] = sel_d_i;
        end

        assign ch_cfg[i].mode = trig_mode_e'(mode_i[MODE_W*i +: MODE_W]);
        assign ch_cfg[i].filt = filt_en_i[i];
        assign ch_clr[i]      = clr_we_i & clr_mask_i[i];

        xirq_pin_sel #(.NUM_PINS(NUM_PINS), .SELW(SELW)) u_sel (
            .pin_i    (pin_i),
            .analog_i (pin_analog_i),
            .idx_i    (ch_idx[i]),
            .bit_o    (ch_raw[i])
        );

        xirq_chan #(.FILT_LEN(FILT_LEN)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (ch_cfg[i]),
            .raw_i  (ch_raw[i]),
            .clr_i  (ch_clr[i]),
            .flag_o (irq_o[i])
        );
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0));
    p_no_mask_no_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_we_i) |=> ((irq_o & $past(irq_o)) == $past(irq_o)));
endmodule

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;
    localparam int NP   = 16;
    localparam int FLEN = 4;
    localparam int SW   = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin;
    logic [NP-1:0] ana;
    logic [11:0]   mode;
    logic [3:0]    filt;
    logic [SW-1:0] sel_c;
    logic [SW-1:0] sel_d;
    logic          clr_we;
    logic [3:0]    clr_mask;
    logic [3:0]    irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    xirq_ctrl #(.NUM_PINS(NP), .FILT_LEN(FLEN)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .pin_i        (pin),
        .pin_analog_i (ana),
        .mode_i       (mode),
        .filt_en_i    (filt),
        .sel_c_i      (sel_c),
        .sel_d_i      (sel_d),
        .clr_we_i     (clr_we),
        .clr_mask_i   (clr_mask),
        .irq_o        (irq)
    );

    // behavioural reference: per-channel pipeline of sampled values
    logic m_s1 [4];
    logic m_s2 [4];
    logic m_hist [4][FLEN];
    logic m_filt [4];
    logic m_prev [4];
    logic m_flag [4];

    function automatic int pin_of(int ch);
        if (ch == 0) return 0;
        if (ch == 1) return 1;
        if (ch == 2) return int'(sel_c);
        return int'(sel_d);
    endfunction

    function automatic string tag_of(int ch);
        int m = int'(mode[3*ch +: 3]);
        if (m >= 1 && m <= 3) return "R3";
        if (m == 4 || m == 5) return "R4";
        return "R5";
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (rst) begin
                m_s1[c] = 0; m_s2[c] = 0; m_filt[c] = 0; m_prev[c] = 0; m_flag[c] = 0;
                for (int k = 0; k < FLEN; k++) m_hist[c][k] = 0;
            end else begin
                logic lv, eg, lh, cl, alleq;
                int md;
                md = int'(mode[3*c +: 3]);
                lv = filt[c] ? m_filt[c] : m_s2[c];
                eg = (md == 1 && lv && !m_prev[c]) || (md == 2 && !lv && m_prev[c])
                     || (md == 3 && lv != m_prev[c]);
                lh = (md == 4 && lv) || (md == 5 && !lv);
                cl = clr_we && clr_mask[c];
                m_flag[c] = eg || (lh && !cl) || (m_flag[c] && !cl);
                m_prev[c] = lv;
                for (int k = FLEN-1; k > 0; k--) m_hist[c][k] = m_hist[c][k-1];
                m_hist[c][0] = m_s2[c];
                alleq = 1;
                for (int k = 1; k < FLEN; k++) if (m_hist[c][k] != m_hist[c][0]) alleq = 0;
                if (alleq) m_filt[c] = m_s2[c];
                m_s2[c] = m_s1[c];
                m_s1[c] = pin[pin_of(c)] | ana[pin_of(c)];
            end
        end
    end

    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            total++;
            if (irq[c] !== m_flag[c]) begin
                bad++;
                $display("FAIL %s model ch%0d got=%0d exp=%0d", tag_of(c), c, irq[c], m_flag[c]);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear(logic [3:0] m);
        clr_we = 1; clr_mask = m;
        tick(1);
        clr_we = 0; clr_mask = 0;
    endtask

    function automatic logic [11:0] modes(int a, int b, int c, int d);
        return {3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; pin = 0; ana = 0; mode = 0; filt = 0;
        sel_c = 4'd5; sel_d = 4'd7; clr_we = 0; clr_mask = 0;
        tick(3);
        chk("R1", "irq after reset", int'(irq), 0);
        rst = 0;
        mode = modes(1, 2, 3, 4);
        tick(4);
        chk("R1", "idle irq", int'(irq), 0);

        // R2 latency
        pin[0] = 1;
        tick(2);
        chk("R2", "flag before 3rd edge", int'(irq[0]), 0);
        tick(1);
        chk("R2", "flag at 3rd edge", int'(irq[0]), 1);

        // R6 masked clear
        clear(4'b1110);
        chk("R6", "zero mask bit keeps flag", int'(irq[0]), 1);
        clear(4'b0001);
        chk("R6", "one mask bit clears flag", int'(irq[0]), 0);

        // R3 falling mode on B
        pin[1] = 1; tick(5);
        chk("R3", "fall mode ignores rise", int'(irq[1]), 0);
        pin[1] = 0; tick(5);
        chk("R3", "fall mode takes fall", int'(irq[1]), 1);
        clear(4'b1111);

        // R10 / R12 pin routing
        pin[4] = 1; tick(5);
        chk("R10", "unselected pin ignored", int'(irq), 0);
        pin[5] = 1; tick(5);
        chk("R12", "only C bit set", int'(irq), 4'b0100);
        clear(4'b1111);
        pin[5] = 0; tick(5);
        chk("R3", "both mode takes fall", int'(irq[2]), 1);
        clear(4'b1111);

        // R7 edge beats clear
        pin[0] = 0; tick(5);
        clear(4'b0001);
        pin[0] = 1; tick(2);
        clear(4'b0001);
        chk("R7", "edge with clear keeps flag", int'(irq[0]), 1);

        // R4 / R8 level on D
        pin[7] = 1; tick(5);
        chk("R4", "high level sets", int'(irq[3]), 1);
        clear(4'b1000);
        chk("R8", "cleared for one cycle", int'(irq[3]), 0);
        tick(1);
        chk("R8", "re-set while active", int'(irq[3]), 1);
        pin[7] = 0; tick(4);
        clear(4'b1000);
        tick(3);
        chk("R4", "stays clear when inactive", int'(irq[3]), 0);
        clear(4'b1111);

        // R5 disabled codes
        mode = modes(6, 2, 3, 4);
        pin[0] = 0; tick(5); pin[0] = 1; tick(5);
        chk("R5", "code 6 never sets", int'(irq[0]), 0);
        mode = modes(0, 2, 3, 4);
        pin[0] = 0; tick(5); pin[0] = 1; tick(5);
        chk("R5", "code 0 never sets", int'(irq[0]), 0);
        mode = modes(1, 2, 3, 4);
        pin[0] = 0; tick(5); pin[0] = 1; tick(5);
        mode = modes(7, 2, 3, 4);
        tick(5);
        chk("R5", "flag retained in code 7", int'(irq[0]), 1);
        mode = modes(1, 2, 3, 4);

        // R9 filter
        pin[0] = 0; tick(6);
        clear(4'b0001);
        filt[0] = 1; tick(2);
        pin[0] = 1; tick(FLEN-1); pin[0] = 0; tick(10);
        chk("R9", "short pulse filtered", int'(irq[0]), 0);
        pin[0] = 1; tick(FLEN); pin[0] = 0; tick(10);
        chk("R9", "full pulse accepted", int'(irq[0]), 1);
        clear(4'b0001);
        filt[0] = 0; tick(2);
        pin[0] = 1; tick(1); pin[0] = 0; tick(5);
        chk("R9", "unfiltered 1-cycle pulse", int'(irq[0]), 1);
        clear(4'b1111);

        // R11 analog pin
        pin[5] = 1; tick(5);
        clear(4'b1111);
        ana[5] = 1;
        pin[5] = 0; tick(5);
        chk("R11", "analog pin blocks fall", int'(irq[2]), 0);
        pin[5] = 1; tick(5);
        chk("R11", "analog pin blocks rise", int'(irq[2]), 0);
        ana[5] = 0;
        tick(5);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 250 == 0) begin
                mode  = 12'($urandom);
                filt  = 4'($urandom);
                sel_c = 4'($urandom);
                sel_d = 4'($urandom);
                ana   = ($urandom % 4 == 0) ? NP'($urandom) : '0;
            end
            if ($urandom % 3 == 0) pin = pin ^ (NP'(1) << ($urandom % NP));
            if ($urandom % 5 == 0) begin
                clr_we = 1; clr_mask = 4'($urandom);
            end else begin
                clr_we = 0; clr_mask = 0;
            end
            tick(1);
        end
        clr_we = 0;
        tick(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule